// File: doc/BRIEF.md
# Adaptive Luma/Chroma Splitter

This block takes a stream of 8-bit composite colour video samples. The samples are taken at four times the colour subcarrier rate, so each subcarrier period holds four samples. The block splits every sample into a luminance value and a chrominance value. One full video line (910 samples) is held in an internal delay store. Because a line spans a half-integer number of subcarrier periods, the chroma in the stored line is phase-inverted. That lets a sum of the current and stored line cancel chroma, and a difference of the two cancel luma.

For each sample, the block measures how far the current line differs from the stored one. It then takes either the line-comb result (small difference) or a horizontal bandpass result (large difference). A two-bit mode selects one of four behaviours: adaptive choice, forced bandpass, luma passthrough, or forced comb. A peaking enable sharpens the luma output with a three-tap high-frequency boost.

The mode, peaking enable and difference threshold are captured with each accepted sample. They then govern that sample's result. Results leave the block a fixed number of accepted samples later, in every mode, so luma and chroma stay aligned.

Top module: `yc_splitter`

## Requirements
- R1: While reset is asserted and until the first sample is accepted, `out_valid`, `y_out` and `c_out` are all 0.
- R2: `out_valid` is high in exactly the cycle after each cycle with `in_valid` high. After a cycle with `in_valid` low, `y_out` and `c_out` keep their previous values.
- R3: The result for the k-th accepted sample is presented after the (k+16)-th acceptance. With continuous input this is 17 clocks from input to output.
- R4: In mode 2'b11 (comb), with x the sample and d the sample accepted LINE_LEN (910) acceptances earlier, the outputs are y = (x+d+1)>>1 and c = sat(128 + ((x−d+1)>>>1)).
- R5: In mode 2'b01 (bandpass), with b = (2·x[k] − x[k−2] − x[k+2] + 2)>>>2, the outputs are c = sat(128+b) and y = sat(x[k]−b).
- R6: In mode 2'b00 (adaptive), the bandpass result of R5 is used when |x−d| is strictly greater than `corr_thresh`. Otherwise the comb result of R4 is used, including when the two are equal.
- R7: In mode 2'b10 (luma passthrough), y equals the sample itself, and c equals the chroma that mode 2'b00 would give for that sample.
- R8: With `peak_en` high in modes 2'b00, 2'b10 or 2'b11, luma becomes sat(y[k] + ((2·y[k] − y[k−1] − y[k+1] + 2)>>>2)). Here y[·] are the pre-peaking luma values of neighbouring samples, each produced under its own mode.
- R9: In mode 2'b01, `peak_en` has no effect on the luma output.
- R10: Both outputs saturate to the range 0..255. `c_out` is offset binary with 128 meaning zero chroma.
- R11: The mode, `peak_en` and `corr_thresh` values applied to a sample are those present in the cycle it was accepted. Values present in cycles with `in_valid` low are ignored.
- R12: Reset clears the line store and all tap history, so samples before the first accepted one count as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample and controls are accepted this cycle |
| in_sample | input | 8 | Composite video sample |
| in_mode | input | 2 | 00 adaptive, 01 bandpass, 10 luma passthrough, 11 comb |
| peak_en | input | 1 | Luma peaking enable |
| corr_thresh | input | 8 | Line-difference threshold for the adaptive choice |
| out_valid | output | 1 | New result on the outputs |
| y_out | output | 8 | Luminance result |
| c_out | output | 8 | Chrominance result, offset binary |

## Verification
The peaking of one sample and the path choice of its two neighbours fall in the same cycle. A sample's luma is boosted using neighbours that may have come through the comb, the bandpass, or the passthrough. The bench provokes this by changing mode, peaking enable and threshold on every accepted sample in its final segments, while dropping `in_valid` at random. A behavioural reference recomputes each neighbour under its own recorded controls and compares both outputs after every acceptance. The same checks also watch that nothing moves while the stream is paused.

// File: rtl/yc_pkg.sv
package yc_pkg;

   typedef enum logic [1:0] {
      MODE_ADAPT = 2'b00,
      MODE_BPF   = 2'b01,
      MODE_YTHRU = 2'b10,
      MODE_COMB  = 2'b11
   } yc_mode_e;

   typedef struct packed {
      yc_mode_e mode;
      logic     peak;
   } yc_ctrl_t;

endpackage

// File: rtl/yc_line_store.sv
module yc_line_store #(
   parameter int W     = 8,
   parameter int DEPTH = 910
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   localparam int AW = $clog2(DEPTH);
   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp   <= '0;
         dout <= '0;
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (en) begin
         dout    <= mem[wp];
         mem[wp] <= din;
         wp      <= (wp == LAST) ? '0 : wp + 1'b1;
      end
   end
endmodule

// File: rtl/yc_separator.sv
module yc_separator
   import yc_pkg::*;
#(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic [W-1:0] x_lead,
   input  logic [W-1:0] x_mid,
   input  logic [W-1:0] x_lag,
   input  logic [W-1:0] x_line,
   input  yc_ctrl_t     ctrl_in,
   input  logic [W-1:0] thr,
   output logic [W-1:0] y_q,
   output logic [W-1:0] c_q,
   output yc_ctrl_t     ctrl_q
);
   localparam int SW = W + 4;
   localparam logic signed [SW-1:0] ONE  = SW'(1);
   localparam logic signed [SW-1:0] TWO  = SW'(2);
   localparam logic signed [SW-1:0] CZ   = SW'(1 << (W - 1));
   localparam logic signed [SW-1:0] VMAX = SW'((1 << W) - 1);

   function automatic logic [W-1:0] sat(input logic signed [SW-1:0] v);
      if (v < 0)    return '0;
      if (v > VMAX) return '1;
      return v[W-1:0];
   endfunction

   logic signed [SW-1:0] sm, sa, sl, sd, st;
   logic signed [SW-1:0] diff, adiff, comb_c, bp_sum, bp, y_bp_raw, y_cb_raw;
   logic                 use_bp;
   logic [W-1:0]         c_comb, c_bp, y_bp, y_cb, y_nx, c_nx;

   assign sm = $signed({4'b0000, x_mid});
   assign sa = $signed({4'b0000, x_lead});
   assign sl = $signed({4'b0000, x_lag});
   assign sd = $signed({4'b0000, x_line});
   assign st = $signed({4'b0000, thr});

   always_comb begin
      diff     = sm - sd;
      adiff    = (diff < 0) ? -diff : diff;
      use_bp   = adiff > st;
      comb_c   = (diff + ONE) >>> 1;
      bp_sum   = (sm <<< 1) - sa - sl + TWO;
      bp       = bp_sum >>> 2;
      y_bp_raw = sm - bp;
      y_cb_raw = (sm + sd + ONE) >>> 1;
      c_comb   = sat(comb_c + CZ);
      c_bp     = sat(bp + CZ);
      y_bp     = sat(y_bp_raw);
      y_cb     = sat(y_cb_raw);
      unique case (ctrl_in.mode)
         MODE_BPF: begin
            y_nx = y_bp;
            c_nx = c_bp;
         end
         MODE_COMB: begin
            y_nx = y_cb;
            c_nx = c_comb;
         end
         MODE_YTHRU: begin
            y_nx = x_mid;
            c_nx = use_bp ? c_bp : c_comb;
         end
         default: begin
            y_nx = use_bp ? y_bp : y_cb;
            c_nx = use_bp ? c_bp : c_comb;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         y_q    <= '0;
         c_q    <= '0;
         ctrl_q <= '0;
      end else if (en) begin
         y_q    <= y_nx;
         c_q    <= c_nx;
         ctrl_q <= ctrl_in;
      end
   end
endmodule

// File: rtl/yc_peaker.sv
module yc_peaker
   import yc_pkg::*;
#(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic [W-1:0] y_in,
   input  logic [W-1:0] c_in,
   input  yc_ctrl_t     ctrl_in,
   output logic [W-1:0] y_q,
   output logic [W-1:0] c_q
);
   localparam int SW = W + 4;
   localparam logic signed [SW-1:0] TWO  = SW'(2);
   localparam logic signed [SW-1:0] VMAX = SW'((1 << W) - 1);

   function automatic logic [W-1:0] sat(input logic signed [SW-1:0] v);
      if (v < 0)    return '0;
      if (v > VMAX) return '1;
      return v[W-1:0];
   endfunction

   logic [W-1:0] ys [3];
   logic [W-1:0] cd [2];
   yc_ctrl_t     cs [2];

   logic signed [SW-1:0] yn, yc, yp, boost;
   logic                 apply;
   logic [W-1:0]         y_nx;

   assign yn = $signed({4'b0000, ys[0]});
   assign yc = $signed({4'b0000, ys[1]});
   assign yp = $signed({4'b0000, ys[2]});

   always_comb begin
      boost = ((yc <<< 1) - yp - yn + TWO) >>> 2;
      apply = cs[1].peak && (cs[1].mode != MODE_BPF);
      y_nx  = apply ? sat(yc + boost) : ys[1];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 3; i++) ys[i] <= '0;
         for (int i = 0; i < 2; i++) begin
            cd[i] <= '0;
            cs[i] <= '0;
         end
         y_q <= '0;
         c_q <= '0;
      end else if (en) begin
         ys[0] <= y_in;
         ys[1] <= ys[0];
         ys[2] <= ys[1];
         cd[0] <= c_in;
         cd[1] <= cd[0];
         cs[0] <= ctrl_in;
         cs[1] <= cs[0];
         y_q   <= y_nx;
         c_q   <= cd[1];
      end
   end
endmodule

// File: rtl/yc_delay.sv
module yc_delay #(
   parameter int W     = 16,
   parameter int DEPTH = 10
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   if (DEPTH == 0) begin : g_wire
      assign dout = din;
   end else begin : g_regs
      logic [W-1:0] st [DEPTH];
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) st[i] <= '0;
         end else if (en) begin
            st[0] <= din;
            for (int i = 1; i < DEPTH; i++) st[i] <= st[i-1];
         end
      end
      assign dout = st[DEPTH-1];
   end
endmodule

// File: rtl/yc_splitter.sv
module yc_splitter
   import yc_pkg::*;
#(
   parameter int W        = 8,
   parameter int LINE_LEN = 910,
   parameter int LATENCY  = 17
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   input  logic [W-1:0] in_sample,
   input  logic [1:0]   in_mode,
   input  logic         peak_en,
   input  logic [W-1:0] corr_thresh,
   output logic         out_valid,
   output logic [W-1:0] y_out,
   output logic [W-1:0] c_out
);
   localparam int TAPS     = 5;
   localparam int MID      = TAPS / 2;
   localparam int CORE_LAT = 7;
   localparam int PAD      = LATENCY - CORE_LAT;

   if (W < 4) begin : g_bad_w
      $error("yc_splitter: W must be at least 4");
   end
   if (LINE_LEN < 8) begin : g_bad_line
      $error("yc_splitter: LINE_LEN too short");
   end
   if (LATENCY < CORE_LAT) begin : g_bad_lat
      $error("yc_splitter: LATENCY below pipeline core depth");
   end

   logic [W-1:0] xs [TAPS];
   logic [W-1:0] ld [MID+1];
   yc_ctrl_t     cw [MID+1];
   logic [W-1:0] tw [MID+1];
   yc_ctrl_t     ctrl_now;

   logic [W-1:0] x_mid;
   logic [1:0]   mode_mid;
   logic [W-1:0] sep_y, sep_c, post_y, post_c;
   yc_ctrl_t     sep_ctrl;
   logic [2*W-1:0] pad_q;

   assign ctrl_now = '{mode: yc_mode_e'(in_mode), peak: peak_en};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < TAPS; i++) xs[i] <= '0;
         for (int i = 1; i <= MID; i++) ld[i] <= '0;
         for (int i = 0; i <= MID; i++) begin
            cw[i] <= '0;
            tw[i] <= '0;
         end
      end else if (in_valid) begin
         xs[0] <= in_sample;
         for (int i = 1; i < TAPS; i++) xs[i] <= xs[i-1];
         for (int i = 1; i <= MID; i++) ld[i] <= ld[i-1];
         cw[0] <= ctrl_now;
         tw[0] <= corr_thresh;
         for (int i = 1; i <= MID; i++) begin
            cw[i] <= cw[i-1];
            tw[i] <= tw[i-1];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) out_valid <= 1'b0;
      else        out_valid <= in_valid;
   end

   yc_line_store #(.W(W), .DEPTH(LINE_LEN)) u_line (
      .clk (clk),
      .rst_n (rst_n),
      .en  (in_valid),
      .din (in_sample),
      .dout(ld[0])
   );

   assign x_mid    = xs[MID];
   assign mode_mid = cw[MID].mode;

   yc_separator #(.W(W)) u_sep (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (in_valid),
      .x_lead (xs[0]),
      .x_mid  (x_mid),
      .x_lag  (xs[TAPS-1]),
      .x_line (ld[MID]),
      .ctrl_in(cw[MID]),
      .thr    (tw[MID]),
      .y_q    (sep_y),
      .c_q    (sep_c),
      .ctrl_q (sep_ctrl)
   );

   yc_peaker #(.W(W)) u_peak (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (in_valid),
      .y_in   (sep_y),
      .c_in   (sep_c),
      .ctrl_in(sep_ctrl),
      .y_q    (post_y),
      .c_q    (post_c)
   );

   yc_delay #(.W(2*W), .DEPTH(PAD)) u_pad (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (in_valid),
      .din  ({post_y, post_c}),
      .dout (pad_q)
   );

   assign y_out = pad_q[2*W-1:W];
   assign c_out = pad_q[W-1:0];
endmodule

// File: rtl/yc_splitter_chk.sv
module yc_splitter_chk #(
   parameter int W = 8
) (
   input logic         clk,
   input logic         rst_n,
   input logic         in_valid,
   input logic         out_valid,
   input logic [W-1:0] y_out,
   input logic [W-1:0] c_out,
   input logic [W-1:0] x_mid,
   input logic [1:0]   mode_mid,
   input logic [W-1:0] sep_y,
   input logic [W-1:0] sep_c
);
   localparam int CZ = 1 << (W - 1);
   localparam int VMAX = (1 << W) - 1;

   // R2: one result strobe per accepted sample
   assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   // R2: idle cycles move nothing
   assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && $stable(y_out) && $stable(c_out)));

   // R7: passthrough luma is the centre sample of the tap window
   assert_thru_luma_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && mode_mid == 2'b10) |=> (sep_y == $past(x_mid)));

   // R4: comb luma plus signed comb chroma rebuilds the sample within one LSB
   assert_comb_sum_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && mode_mid == 2'b11) |=>
         ((int'(sep_y) + int'(sep_c) - CZ - int'($past(x_mid))) == 0 ||
          (int'(sep_y) + int'(sep_c) - CZ - int'($past(x_mid))) == 1));

   // R5: unsaturated bandpass luma and chroma add back to the sample
   assert_bpf_sum_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && mode_mid == 2'b01) |=>
         ((int'(sep_c) == VMAX || int'(sep_y) == 0 || int'(sep_y) == VMAX) ||
          (int'(sep_y) + int'(sep_c) - CZ == int'($past(x_mid)))));
endmodule

bind yc_splitter yc_splitter_chk #(.W(W)) u_chk (.*);

// File: tb/yc_splitter_bench.sv
module yc_splitter_bench;
   localparam int LINE  = 910;
   localparam int LAT   = 16;
   localparam int NACC  = 12 * 455;
   localparam int NMAX  = NACC + 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic [7:0] in_sample = '0;
   logic [1:0] in_mode = '0;
   logic       peak_en = 1'b0;
   logic [7:0] corr_thresh = '0;
   logic       out_valid;
   logic [7:0] y_out, c_out;

   int checks = 0;
   int fails  = 0;
   int xa [NMAX];
   int md [NMAX];
   int pk [NMAX];
   int th [NMAX];

   always #2 clk = ~clk;

   yc_splitter u_yc_splitter (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
      .in_mode(in_mode), .peak_en(peak_en), .corr_thresh(corr_thresh),
      .out_valid(out_valid), .y_out(y_out), .c_out(c_out)
   );

   function automatic int xv(int i);
      if (i < 0) return 0;
      return xa[i];
   endfunction

   function automatic int sat(int v);
      if (v < 0) return 0;
      if (v > 255) return 255;
      return v;
   endfunction

   function automatic bit pick_bp(int k);
      int diff = xv(k) - xv(k - LINE);
      if (diff < 0) diff = -diff;
      return diff > th[k];
   endfunction

   function automatic int ysep(int k);
      int xm, d, bp, ybp, ycb;
      if (k < 0) return 0;
      xm  = xv(k);
      d   = xv(k - LINE);
      bp  = (2 * xm - xv(k - 2) - xv(k + 2) + 2) >>> 2;
      ybp = sat(xm - bp);
      ycb = sat((xm + d + 1) >>> 1);
      case (md[k])
         1:       return ybp;
         2:       return xm;
         3:       return ycb;
         default: return pick_bp(k) ? ybp : ycb;
      endcase
   endfunction

   function automatic int csep(int k);
      int xm, d, bp, cbp, ccb;
      xm  = xv(k);
      d   = xv(k - LINE);
      bp  = (2 * xm - xv(k - 2) - xv(k + 2) + 2) >>> 2;
      cbp = sat(bp + 128);
      ccb = sat(((xm - d + 1) >>> 1) + 128);
      case (md[k])
         1:       return cbp;
         3:       return ccb;
         default: return pick_bp(k) ? cbp : ccb;
      endcase
   endfunction

   function automatic int yfin(int k);
      int y = ysep(k);
      if (pk[k] != 0 && md[k] != 1)
         return sat(y + ((2 * y - ysep(k - 1) - ysep(k + 1) + 2) >>> 2));
      return y;
   endfunction

   function automatic string tag_of(int k, int ey, int ec);
      if (ey == 0 || ey == 255 || ec == 0 || ec == 255) return "R10";
      if (k < LINE)                  return "R12";
      if (pk[k] != 0 && md[k] != 1)  return "R8";
      if (pk[k] != 0)                return "R9";
      case (md[k])
         0:       return "R6";
         1:       return "R5";
         2:       return "R7";
         default: return "R4";
      endcase
   endfunction

   int  acc = 0;
   bit  prev_v = 1'b0;
   int  last_y = 0;
   int  last_c = 0;

   task automatic check_cycle();
      int j, ey, ec;
      string t;
      checks++;
      if (out_valid !== prev_v) begin
         fails++;
         $display("FAIL R2 out_valid actual=%0b expected=%0b", out_valid, prev_v);
      end
      if (prev_v) begin
         j = acc - 1 - LAT;
         if (j >= 0) begin
            ey = yfin(j);
            ec = csep(j);
            t  = tag_of(j, ey, ec);
            checks++;
            if (int'(y_out) != ey || int'(c_out) != ec) begin
               fails++;
               $display("FAIL %s R3 R11 sample %0d y actual=%0d expected=%0d c actual=%0d expected=%0d",
                        t, j, y_out, ey, c_out, ec);
            end
         end
      end else begin
         checks++;
         if (int'(y_out) != last_y || int'(c_out) != last_c) begin
            fails++;
            $display("FAIL R2 hold y actual=%0d expected=%0d c actual=%0d expected=%0d",
                     y_out, last_y, c_out, last_c);
         end
      end
      last_y = int'(y_out);
      last_c = int'(c_out);
   endtask

   function automatic int gen_sample(int k);
      int hl = k / 455;
      int ph = k % 4;
      case (hl % 3)
         0:       return 120 + ((ph == 0) ? 60 : (ph == 2) ? -60 : 0) + int'($urandom % 5);
         1:       return (($urandom % 4) == 0) ? int'($urandom % 256) : ((ph < 2) ? 255 : 0);
         default: return int'($urandom % 256);
      endcase
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      checks++;
      if (out_valid !== 1'b0 || y_out !== 8'd0 || c_out !== 8'd0) begin
         fails++;
         $display("FAIL R1 reset actual=%0b/%0d/%0d expected=0/0/0", out_valid, y_out, c_out);
      end
      rst_n = 1'b1;
      @(negedge clk);
      checks++;
      if (out_valid !== 1'b0 || y_out !== 8'd0 || c_out !== 8'd0) begin
         fails++;
         $display("FAIL R1 after reset actual=%0b/%0d/%0d expected=0/0/0", out_valid, y_out, c_out);
      end
      while (acc < NACC) begin
         @(negedge clk);
         check_cycle();
         if (($urandom % 8) != 0) begin
            int hl = acc / 455;
            xa[acc] = gen_sample(acc);
            md[acc] = (hl < 8) ? (hl % 4) : int'($urandom % 4);
            pk[acc] = int'($urandom % 2);
            th[acc] = int'($urandom % 64);
            in_valid    = 1'b1;
            in_sample   = 8'(xa[acc]);
            in_mode     = 2'(md[acc]);
            peak_en     = pk[acc][0];
            corr_thresh = 8'(th[acc]);
            acc++;
            prev_v = 1'b1;
         end else begin
            // R11: controls and data in idle cycles must be ignored
            in_valid    = 1'b0;
            in_sample   = 8'($urandom);
            in_mode     = 2'($urandom);
            peak_en     = 1'($urandom);
            corr_thresh = 8'($urandom);
            prev_v = 1'b0;
         end
      end
      repeat (4) begin
         @(negedge clk);
         check_cycle();
         in_valid = 1'b0;
         prev_v = 1'b0;
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #(4 * 200000);
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule